// File: doc/BRIEF.md
# Floating-Point Register Stack Renamer

This block sits in front of a floating-point register file whose operands are named relative to a top-of-stack position rather than by absolute register number. It keeps a circular top pointer, an empty/valid tag per stack slot and a rename table that binds every stack slot to one of eight physical registers. Each cycle it turns a stack-relative instruction into physical read and write addresses. The register file itself lives outside the block, and the block moves no data.

An instruction may push a new value, read the top of stack together with any relative slot, write a relative slot, and pop the top. Every read pair includes the current top, because each arithmetic operation takes one of its sources from there. A separate exchange request can be issued in the same cycle as a read or write instruction. The exchange swaps the rename entries of the top slot and a chosen slot, finishes in one cycle and copies no register contents. Stack misuse is reported through overflow and underflow flags that are valid in the same cycle as the request.

Top module: `fpStackRenamer`

## Requirements
- R1: After reset the top pointer is 0, every slot is empty, and slot k maps to physical register k. So with the top at 0, relative index i reads physical register i.
- R2: Relative index i selects slot (top + i) mod 8, and that slot is translated through the rename table. `rdPhysTop` always gives the register holding relative index 0, and `rdPhysIdx` gives the one holding index `insIdx`.
- R3: A push (`insValid`=1, `insPush`=1) targets slot (top − 1) mod 8. If that slot is empty, the push asserts `wrEn` with `wrPhys` set to that slot's register, marks the slot valid and makes it the new top. If the slot is valid (all eight in use), the push raises `ovfl` and does not write or change any state. `insPop` and `insWrite` have no effect during a push.
- R4: A pop (`insPop`=1 without push) empties the top slot and advances the top by one. If the instruction underflows, the pop changes no state.
- R5: A non-push instruction raises `unfl` when the top slot or slot (top + `insIdx`) is empty. In that case the instruction's write and pop are suppressed. `ovfl` and `unfl` are never raised together.
- R6: An exchange (`xchValid`=1) swaps the rename entries of the top slot and slot (top + `xchIdx`) at the next clock edge. It asserts no write. From the following cycle on, reads at those two relative positions return each other's registers.
- R7: An exchange issued together with a read or write instruction is applied after that instruction's addresses are formed, so the instruction uses the mapping from before the swap.
- R8: An exchange requested in the same cycle as a push or a pop instruction is ignored, and the mapping is unchanged.
- R9: An exchange where the top slot or slot (top + `xchIdx`) is empty raises `unfl` and leaves the mapping unchanged.
- R10: The top pointer wraps modulo 8. The first push after reset writes through slot 7 (physical register 7), and eight pops after eight pushes bring the top back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | Instruction present this cycle |
| insPush | input | 1 | Instruction pushes a new top |
| insPop | input | 1 | Instruction pops the top after use |
| insWrite | input | 1 | Instruction writes relative slot `insIdx` |
| insIdx | input | 3 | Relative index of the second operand |
| xchValid | input | 1 | Exchange request this cycle |
| xchIdx | input | 3 | Relative index exchanged with the top |
| rdPhysTop | output | 3 | Physical register of relative index 0 |
| rdPhysIdx | output | 3 | Physical register of relative index `insIdx` |
| wrEn | output | 1 | Register-file write strobe |
| wrPhys | output | 3 | Physical register to write |
| ovfl | output | 1 | Push onto a full stack |
| unfl | output | 1 | Use of an empty slot by the instruction or the exchange |

## Verification
The bench models the stack as a queue of values held in a register file that the bench owns. It writes through `wrPhys` and checks every read through `rdPhysTop` and `rdPhysIdx`, so a wrong rename entry shows up as a wrong value, not as a wrong address that happens to match. The bench targets the following cases, each of which a faulty design would get visibly wrong:
- A push when the top pointer wraps from 0 to 7. A design without modulo arithmetic would write the wrong register.
- A push onto a full stack. A design that still wrote here would overwrite a live value, which later reads would expose.
- An exchange issued together with a write. A design that applied the swap first would put the written value into the wrong slot.
- An exchange issued together with a pop, and an exchange that touches an empty slot. A design that did not ignore these would scramble the order of the stack.
- Pops of an empty stack. A design that let these through would leave the top pointer skewed, which later reads would expose.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  // Strobes from control to datapath, one per state change.
  typedef struct packed {
    logic doPush;
    logic doPop;
    logic doWrite;
    logic doXch;
  } fpsrStrobes_t;
endpackage

// File: rtl/fpsrControl.sv
module fpsrControl
  import fpsr_pkg::*;
(
  input  logic         insValid,
  input  logic         insPush,
  input  logic         insPop,
  input  logic         insWrite,
  input  logic         xchValid,
  input  logic         tagTop,
  input  logic         tagIdx,
  input  logic         tagNew,
  input  logic         tagXch,
  output fpsrStrobes_t strobes,
  output logic         ovfl,
  output logic         unfl
);
  logic pushReq, useReq, insUnfl, xchAllowed, xchUnfl;

  always_comb begin
    pushReq    = insValid && insPush;
    useReq     = insValid && !insPush;
    // Every operation pairs the top with one relative slot.
    insUnfl    = useReq && !(tagTop && tagIdx);
    // Exchange only coexists with instructions that keep the top in place.
    xchAllowed = xchValid && !(insValid && (insPush || insPop));
    xchUnfl    = xchAllowed && !(tagTop && tagXch);

    ovfl = pushReq && tagNew;
    unfl = insUnfl || xchUnfl;

    strobes.doPush  = pushReq && !tagNew;
    strobes.doPop   = useReq && insPop && !insUnfl;
    strobes.doWrite = useReq && insWrite && !insUnfl;
    strobes.doXch   = xchAllowed && !xchUnfl;
  end
endmodule

// File: rtl/fpsrDatapath.sv
module fpsrDatapath
  import fpsr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  fpsrStrobes_t  strobes,
  input  logic [IW-1:0] insIdx,
  input  logic [IW-1:0] xchIdx,
  output logic [IW-1:0] physTop,
  output logic [IW-1:0] physIdx,
  output logic [IW-1:0] physXch,
  output logic [IW-1:0] wrPhys,
  output logic          wrEn,
  output logic          tagTop,
  output logic          tagIdx,
  output logic          tagNew,
  output logic          tagXch
);
  logic [IW-1:0]    topPtr;
  logic [IW-1:0]    renameMap [DEPTH];
  logic [DEPTH-1:0] slotTag;
  logic [IW-1:0]    slotIdx, slotNew, slotXch, physNew;

  always_comb begin
    // IW-bit sums wrap modulo DEPTH.
    slotIdx = topPtr + insIdx;
    slotXch = topPtr + xchIdx;
    slotNew = topPtr - IW'(1);
    physTop = renameMap[topPtr];
    physIdx = renameMap[slotIdx];
    physXch = renameMap[slotXch];
    physNew = renameMap[slotNew];
    tagTop  = slotTag[topPtr];
    tagIdx  = slotTag[slotIdx];
    tagXch  = slotTag[slotXch];
    tagNew  = slotTag[slotNew];
    wrEn    = strobes.doPush || strobes.doWrite;
    wrPhys  = strobes.doPush ? physNew : physIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topPtr  <= '0;
      slotTag <= '0;
      for (int k = 0; k < DEPTH; k++) renameMap[k] <= IW'(k);
    end else begin
      if (strobes.doXch) begin
        renameMap[topPtr]  <= renameMap[slotXch];
        renameMap[slotXch] <= renameMap[topPtr];
      end
      if (strobes.doPush) begin
        slotTag[slotNew] <= 1'b1;
        topPtr           <= slotNew;
      end else if (strobes.doPop) begin
        slotTag[topPtr] <= 1'b0;
        topPtr          <= topPtr + IW'(1);
      end
    end
  end
endmodule

// File: rtl/fpStackRenamer.sv
module fpStackRenamer
  import fpsr_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          insValid,
  input  logic          insPush,
  input  logic          insPop,
  input  logic          insWrite,
  input  logic [IW-1:0] insIdx,
  input  logic          xchValid,
  input  logic [IW-1:0] xchIdx,
  output logic [IW-1:0] rdPhysTop,
  output logic [IW-1:0] rdPhysIdx,
  output logic          wrEn,
  output logic [IW-1:0] wrPhys,
  output logic          ovfl,
  output logic          unfl
);
  fpsrStrobes_t  strobes;
  logic          tagTop, tagIdx, tagNew, tagXch;
  logic [IW-1:0] xchPhys;

  fpsrControl u_ctrl (
    .insValid(insValid), .insPush(insPush), .insPop(insPop),
    .insWrite(insWrite), .xchValid(xchValid),
    .tagTop(tagTop), .tagIdx(tagIdx), .tagNew(tagNew), .tagXch(tagXch),
    .strobes(strobes), .ovfl(ovfl), .unfl(unfl)
  );

  fpsrDatapath #(.DEPTH(DEPTH), .IW(IW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .insIdx(insIdx), .xchIdx(xchIdx),
    .physTop(rdPhysTop), .physIdx(rdPhysIdx), .physXch(xchPhys),
    .wrPhys(wrPhys), .wrEn(wrEn),
    .tagTop(tagTop), .tagIdx(tagIdx), .tagNew(tagNew), .tagXch(tagXch)
  );
endmodule

// File: rtl/fpsrChecker.sv
module fpsrChecker #(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic          insValid,
  input logic          insPush,
  input logic          xchValid,
  input logic          ovfl,
  input logic          unfl,
  input logic          wrEn,
  input logic [IW-1:0] wrPhys,
  input logic [IW-1:0] rdPhysTop,
  input logic [IW-1:0] xchPhys
);
  // R3: the register just written by a push is the new top
  p_push_top_r3: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && insPush && !ovfl) |=> rdPhysTop == $past(wrPhys));

  // R3: an overflowing push writes nothing
  p_no_write_on_ovfl_r3: assert property (@(posedge clk) disable iff (!rstN)
    ovfl |-> !wrEn);

  // R5: the two error flags are exclusive
  p_flag_mutex_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfl && unfl));

  // R4: an underflowing instruction leaves the top untouched
  p_unfl_holds_top_r4: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && !insPush && unfl && !xchValid) |=> $stable(rdPhysTop));

  // R6: an exchange by itself moves no data
  p_xch_no_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (xchValid && !insValid) |-> !wrEn);

  // R6: after an exchange the top holds the partner's register
  p_xch_swaps_r6: assert property (@(posedge clk) disable iff (!rstN)
    (xchValid && !insValid && !unfl) |=> rdPhysTop == $past(xchPhys));
endmodule

bind fpStackRenamer fpsrChecker #(.IW(IW)) u_chk (
  .clk(clk), .rstN(rstN), .insValid(insValid), .insPush(insPush),
  .xchValid(xchValid), .ovfl(ovfl), .unfl(unfl), .wrEn(wrEn),
  .wrPhys(wrPhys), .rdPhysTop(rdPhysTop), .xchPhys(xchPhys)
);

// File: tb/fpStackRenamer_bench.sv
module fpStackRenamer_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic       insValid, insPush, insPop, insWrite, xchValid;
  logic [2:0] insIdx, xchIdx;
  logic [2:0] rdPhysTop, rdPhysIdx, wrPhys;
  logic       wrEn, ovfl, unfl;

  int checks = 0;
  int failures = 0;
  int regFile [8];
  int model [$];
  int dataSeed = 1000;
  int lastWrPhys;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  fpStackRenamer u_fpStackRenamer (
    .clk(clk), .rstN(rstN), .insValid(insValid), .insPush(insPush),
    .insPop(insPop), .insWrite(insWrite), .insIdx(insIdx),
    .xchValid(xchValid), .xchIdx(xchIdx), .rdPhysTop(rdPhysTop),
    .rdPhysIdx(rdPhysIdx), .wrEn(wrEn), .wrPhys(wrPhys),
    .ovfl(ovfl), .unfl(unfl)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, check before the rising edge,
  // then advance the queue model and the bench-owned register file.
  task automatic step(string req, bit v, bit push, bit pop, bit wr, int idx,
                      bit xv, int xi);
    int  size, data, sWrPhys;
    bit  pushReq, useReq, eOvf, eInsUnf, xAllow, eXUnf, eWr, sWrEn;
    @(negedge clk);
    insValid = v; insPush = push; insPop = pop; insWrite = wr;
    insIdx = 3'(idx); xchValid = xv; xchIdx = 3'(xi);
    dataSeed++;
    data = dataSeed;
    #1;
    size    = model.size();
    pushReq = v && push;
    useReq  = v && !push;
    eOvf    = pushReq && size == 8;
    eInsUnf = useReq && (size == 0 || idx >= size);
    xAllow  = xv && !(v && (push || pop));
    eXUnf   = xAllow && (size == 0 || xi >= size);
    eWr     = (pushReq && !eOvf) || (useReq && wr && !eInsUnf);
    check(req, "ovfl", int'(ovfl), int'(eOvf));
    check(req, "unfl", int'(unfl), int'(eInsUnf || eXUnf));
    check(req, "wrEn", int'(wrEn), int'(eWr));
    if (useReq && !eInsUnf) begin
      check(req, "top value", regFile[rdPhysTop], model[0]);
      check(req, "idx value", regFile[rdPhysIdx], model[idx]);
    end
    sWrEn = wrEn;
    sWrPhys = int'(wrPhys);
    lastWrPhys = sWrPhys;
    @(posedge clk);
    if (sWrEn) regFile[sWrPhys] = data;
    if (pushReq && !eOvf) model.push_front(data);
    else if (useReq && !eInsUnf) begin
      if (wr) model[idx] = data;
      if (pop) void'(model.pop_front());
    end
    if (xAllow && !eXUnf) begin
      int t;
      t = model[0]; model[0] = model[xi]; model[xi] = t;
    end
  endtask

  task automatic idle(string req);
    step(req, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #300000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) regFile[k] = -1;
    rstN = 1'b0; insValid = 0; insPush = 0; insPop = 0; insWrite = 0;
    insIdx = 0; xchValid = 0; xchIdx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: identity mapping, empty stack, top at 0
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      insValid = 1; insPush = 0; insIdx = 3'(i);
      #1;
      check("R1", "reset map", int'(rdPhysIdx), i);
      check("R1", "reset empty unfl", int'(unfl), 1);
      check("R1", "reset top map", int'(rdPhysTop), 0);
    end
    idle("R1");

    // R10: first push wraps the top to slot 7
    step("R10", 1, 1, 0, 0, 0, 0, 0);
    check("R10", "wrap push wrPhys", lastWrPhys, 7);
    // R3: more pushes, then R2 reads at each depth
    for (int i = 0; i < 3; i++) step("R3", 1, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R2", 1, 0, 0, 0, i, 0, 0);
    // R5: read of an empty slot, write to an empty slot
    step("R5", 1, 0, 0, 0, 5, 0, 0);
    step("R5", 1, 0, 0, 1, 6, 0, 0);
    step("R5", 1, 0, 0, 1, 2, 0, 0);
    // R6: exchange alone, then reads
    step("R6", 0, 0, 0, 0, 0, 1, 3);
    for (int i = 0; i < 4; i++) step("R6", 1, 0, 0, 0, i, 0, 0);
    // R7: exchange with a same-cycle write to the partner slot
    step("R7", 1, 0, 0, 1, 2, 1, 2);
    for (int i = 0; i < 4; i++) step("R7", 1, 0, 0, 0, i, 0, 0);
    // R8: exchange paired with pop and with push is ignored
    step("R8", 1, 0, 1, 0, 1, 1, 2);
    for (int i = 0; i < 3; i++) step("R8", 1, 0, 0, 0, i, 0, 0);
    step("R8", 1, 1, 0, 0, 0, 1, 1);
    for (int i = 0; i < 4; i++) step("R8", 1, 0, 0, 0, i, 0, 0);
    // R9: exchange with an empty slot
    step("R9", 0, 0, 0, 0, 0, 1, 6);
    for (int i = 0; i < 4; i++) step("R9", 1, 0, 0, 0, i, 0, 0);
    // R3: fill and overflow
    for (int i = 0; i < 4; i++) step("R3", 1, 1, 0, 0, 0, 0, 0);
    step("R3", 1, 1, 0, 0, 0, 0, 0);
    step("R3", 1, 1, 1, 1, 3, 0, 0);
    for (int i = 0; i < 8; i++) step("R3", 1, 0, 0, 0, i, 0, 0);
    // R4: write-and-pop down to empty, then pops of an empty stack
    for (int i = 0; i < 7; i++) step("R4", 1, 0, 1, 1, 1, 0, 0);
    step("R4", 1, 0, 1, 0, 0, 0, 0);
    step("R4", 1, 0, 1, 0, 0, 0, 0);
    step("R4", 1, 0, 1, 0, 0, 0, 0);
    // R10: top is back where a fresh push lands in a known order
    for (int i = 0; i < 8; i++) step("R10", 1, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) step("R10", 1, 0, 0, 0, i, 0, 0);
    // R2: mixed traffic
    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom_range(0, 9));
      step("R2", 1'($urandom_range(0, 5) != 0), r < 3, r >= 7, r[0],
           int'($urandom_range(0, 7)), 1'($urandom_range(0, 2) == 0),
           int'($urandom_range(0, 7)));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule